// File: doc/BRIEF.md
# CRC-16 Engine with Bit Transpose

This block computes a 16-bit cyclic redundancy check using the CCITT generator x^16 + x^12 + x^5 + 1 (0x1021). A host drives it through a small write port. It first sets a seed, then writes data bytes or 16-bit words, and reads the running CRC from a result output at any time. Each data write advances the CRC state in a single clock, whether it carries 8 or 16 bits.

A control register holds two bits. The first turns data-port writes into seed loads. The second selects transpose mode, for hosts that keep their data least-significant-bit first. In transpose mode each incoming data byte is bit-reversed before it enters the CRC, and the 16-bit result is bit-reversed on its way to the output. The state register itself is always kept in the unreflected form. The seed is therefore taken exactly as written.

Top module: `crc16_engine`

## Requirements
- R1: After reset, crc_out reads 0x0000 and ctl_out reads 0 (seed-load mode off, transpose off).
- R2: A write with wr_sel=0 sets seed-load mode from wr_data bit 0 and transpose mode from wr_data bit 1, and ignores wr_data bits 15:2. ctl_out shows {transpose, seed-load} from the next cycle. The CRC state is left unchanged.
- R3: A write with wr_sel=1 while seed-load mode is on loads all 16 bits of wr_data into the CRC state. wr_wide has no effect on this load, and no bit reversal is applied to it.
- R4: A write with wr_sel=1, seed-load off and wr_wide=0 advances the CRC by the 8 bits of wr_data[7:0] in one clock, most significant bit first, with polynomial 0x1021. wr_data[15:8] has no effect.
- R5: A write with wr_sel=1, seed-load off and wr_wide=1 advances the CRC in one clock by wr_data[15:8] and then by wr_data[7:0].
- R6: With transpose on, each data byte is bit-reversed (bit i to bit 7-i) before it enters the CRC.
- R7: crc_out equals the CRC state when transpose is off. When transpose is on, it equals the state with bit i moved to bit 15-i.
- R8: With seed 0xFFFF and transpose off, the bytes of the ASCII string "123456789" yield 0x29B1. With seed 0x0000 and transpose on, they yield 0x2189.
- R9: While wr_en is low, neither the CRC state nor the control bits change. A data-port write never changes the control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_sel | input | 1 | 0 = control register, 1 = data/seed port |
| wr_wide | input | 1 | Data write width: 0 = byte (low 8 bits), 1 = 16-bit word |
| wr_data | input | 16 | Write data |
| crc_out | output | 16 | Running CRC result, reversed in transpose mode |
| ctl_out | output | 2 | Control readback {transpose, seed-load} |

## Verification
The bench builds the block with its default parameters: a 16-bit CRC, 8-bit lanes, a 16-bit data port and polynomial 0x1021. Because a lane is 8 bits wide, every byte value can be swept in sequence from several seeds in both transpose modes, with each result compared against a CRC computed arithmetically in the bench. Word writes are driven from a bench-side pseudo-random sequence in both modes. Both check strings, the unreversed seed readback and writes that must be ignored are also covered.

// File: rtl/crc16_pkg.sv
package crc16_pkg;

  localparam int CTL_SEED_BIT  = 0;
  localparam int CTL_XPOSE_BIT = 1;

  typedef struct packed {
    logic xpose;
    logic seed_ld;
  } ctl_t;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_CTL,
    OP_SEED,
    OP_DATA
  } op_e;

endpackage

// File: rtl/crc16_ctrl.sv
module crc16_ctrl
  import crc16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output ctl_t              ctl_q,
  output op_e               op
);

  // decode the write into one of the engine operations
  always_comb begin
    if (!wr_en)             op = OP_NONE;
    else if (!wr_sel)       op = OP_CTL;
    else if (ctl_q.seed_ld) op = OP_SEED;
    else                    op = OP_DATA;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (op == OP_CTL) begin
      ctl_q.xpose   <= wr_data[CTL_XPOSE_BIT];
      ctl_q.seed_ld <= wr_data[CTL_SEED_BIT];
    end
  end

endmodule

// File: rtl/crc16_lane.sv
module crc16_lane #(
  parameter int              CRC_W  = 16,
  parameter int              LANE_W = 8,
  parameter logic [CRC_W-1:0] POLY  = 16'h1021
) (
  input  logic [CRC_W-1:0]  crc_in,
  input  logic [LANE_W-1:0] lane_in,
  input  logic              xpose,
  output logic [CRC_W-1:0]  crc_out
);

  // mirror a lane: bit i goes to bit LANE_W-1-i
  function automatic logic [LANE_W-1:0] flip_lane(input logic [LANE_W-1:0] v);
    logic [LANE_W-1:0] r;
    for (int i = 0; i < LANE_W; i++) r[i] = v[LANE_W-1-i];
    return r;
  endfunction

  // serial LFSR step unrolled over one lane, MSB of the lane first
  function automatic logic [CRC_W-1:0] lane_step(input logic [CRC_W-1:0] c_in,
                                                 input logic [LANE_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic             fb;
    c = c_in;
    for (int i = LANE_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    return c;
  endfunction

  logic [LANE_W-1:0] lane_eff;

  assign lane_eff = xpose ? flip_lane(lane_in) : lane_in;
  assign crc_out  = lane_step(crc_in, lane_eff);

endmodule

// File: rtl/crc16_core.sv
module crc16_core
  import crc16_pkg::*;
#(
  parameter int              CRC_W  = 16,
  parameter int              LANE_W = 8,
  parameter int              DATA_W = 16,
  parameter logic [CRC_W-1:0] POLY  = 16'h1021
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op,
  input  logic              wide,
  input  logic              xpose,
  input  logic [DATA_W-1:0] data,
  output logic [CRC_W-1:0]  crc_q
);

  localparam int N_LANES = DATA_W / LANE_W;

  logic [CRC_W-1:0] chain [0:N_LANES];
  logic [CRC_W-1:0] byte_next;

  assign chain[0] = crc_q;

  // word path: lanes in order from the most significant lane down
  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    crc16_lane #(
      .CRC_W (CRC_W),
      .LANE_W(LANE_W),
      .POLY  (POLY)
    ) u_lane (
      .crc_in (chain[g]),
      .lane_in(data[DATA_W-1-g*LANE_W -: LANE_W]),
      .xpose  (xpose),
      .crc_out(chain[g+1])
    );
  end

  // narrow path: only the least significant lane
  crc16_lane #(
    .CRC_W (CRC_W),
    .LANE_W(LANE_W),
    .POLY  (POLY)
  ) u_byte_lane (
    .crc_in (crc_q),
    .lane_in(data[LANE_W-1:0]),
    .xpose  (xpose),
    .crc_out(byte_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '0;
    end else begin
      case (op)
        OP_SEED: crc_q <= data[CRC_W-1:0];
        OP_DATA: crc_q <= wide ? chain[N_LANES] : byte_next;
        default: crc_q <= crc_q;
      endcase
    end
  end

endmodule

// File: rtl/crc16_engine.sv
module crc16_engine
  import crc16_pkg::*;
#(
  parameter int              CRC_W  = 16,
  parameter int              LANE_W = 8,
  parameter int              DATA_W = 16,
  parameter logic [CRC_W-1:0] POLY  = 16'h1021
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic              wr_wide,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CRC_W-1:0]  crc_out,
  output logic [1:0]        ctl_out
);

  ctl_t             ctl_q;
  op_e              op;
  logic [CRC_W-1:0] crc_q;

  // named events for the checker
  logic ctl_fire;
  logic seed_fire;
  logic data_fire;

  assign ctl_fire  = (op == OP_CTL);
  assign seed_fire = (op == OP_SEED);
  assign data_fire = (op == OP_DATA);

  crc16_ctrl #(
    .DATA_W(DATA_W)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .wr_data(wr_data),
    .ctl_q  (ctl_q),
    .op     (op)
  );

  crc16_core #(
    .CRC_W (CRC_W),
    .LANE_W(LANE_W),
    .DATA_W(DATA_W),
    .POLY  (POLY)
  ) u_core (
    .clk  (clk),
    .rst_n(rst_n),
    .op   (op),
    .wide (wr_wide),
    .xpose(ctl_q.xpose),
    .data (wr_data),
    .crc_q(crc_q)
  );

  // readback reversal is pure wiring
  logic [CRC_W-1:0] crc_flip;
  for (genvar b = 0; b < CRC_W; b++) begin : g_flip
    assign crc_flip[b] = crc_q[CRC_W-1-b];
  end

  assign crc_out = ctl_q.xpose ? crc_flip : crc_q;
  assign ctl_out = {ctl_q.xpose, ctl_q.seed_ld};

endmodule

// File: rtl/crc16_engine_chk.sv
module crc16_engine_chk #(
  parameter int CRC_W  = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic [CRC_W-1:0]  crc_q,
  input logic [1:0]        ctl_out,
  input logic              ctl_fire,
  input logic              seed_fire
);

  // R1: while in reset, state and control read as cleared on the next edge
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (crc_q == '0 && ctl_out == 2'b00));

  // R2: a control write updates the control bits from bits 1:0
  p_ctl_update_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_fire |=> ctl_out == {$past(wr_data[1]), $past(wr_data[0])});

  // R2: a control write keeps the CRC state
  p_ctl_keeps_crc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_fire |=> $stable(crc_q));

  // R3: a seed load takes the written word as is
  p_seed_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seed_fire |=> crc_q == $past(wr_data[CRC_W-1:0]));

  // R9: idle cycles change nothing
  p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(crc_q) && $stable(ctl_out)));

  // R9: data-port writes never touch the control bits
  p_data_keeps_ctl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> $stable(ctl_out));

endmodule

bind crc16_engine crc16_engine_chk #(
  .CRC_W (CRC_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_sel   (wr_sel),
  .wr_data  (wr_data),
  .crc_q    (crc_q),
  .ctl_out  (ctl_out),
  .ctl_fire (ctl_fire),
  .seed_fire(seed_fire)
);

// File: tb/crc16_engine_tb_top.sv
module crc16_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic        wr_wide = 1'b0;
  logic [15:0] wr_data = 16'h0000;
  logic [15:0] crc_out;
  logic [1:0]  ctl_out;

  always #4 clk = ~clk;

  crc16_engine dut_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .wr_wide(wr_wide),
    .wr_data(wr_data),
    .crc_out(crc_out),
    .ctl_out(ctl_out)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // bench model of the requirements
  logic [15:0] m_crc = 16'h0000;
  logic        m_seed = 1'b0;
  logic        m_x = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [15:0] m_byte(input logic [15:0] c_in, input logic [7:0] b);
    logic [15:0] c;
    c = c_in ^ {b, 8'h00};
    for (int k = 0; k < 8; k++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    return c;
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) r[7-k] = v[k];
    return r;
  endfunction

  function automatic logic [15:0] rev16(input logic [15:0] v);
    logic [15:0] r;
    for (int k = 0; k < 16; k++) r[15-k] = v[k];
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_crc(input string req);
    check(req, crc_out, m_x ? rev16(m_crc) : m_crc);
  endtask

  task automatic feed(input logic [7:0] b);
    m_crc = m_byte(m_crc, m_x ? rev8(b) : b);
  endtask

  // one write cycle, then model update; outputs are read at the following negedge
  task automatic wr(input logic sel, input logic wide, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_wide = wide; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = ~d;
    if (!sel) begin
      m_seed = d[0];
      m_x = d[1];
    end else if (m_seed) begin
      m_crc = d;
    end else if (wide) begin
      feed(d[15:8]);
      feed(d[7:0]);
    end else begin
      feed(d[7:0]);
    end
  endtask

  task automatic next_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    string msg;
    logic [15:0] seeds [4];
    seeds[0] = 16'h0000; seeds[1] = 16'hFFFF; seeds[2] = 16'h1D0F; seeds[3] = 16'hA5A5;
    msg = "123456789";

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 crc", crc_out, 16'h0000);
    check("R1 ctl", {14'h0, ctl_out}, 16'h0000);

    // R2: upper bits ignored, CRC untouched
    wr(1'b0, 1'b0, 16'hFFFC);
    check("R2 ctl upper ignored", {14'h0, ctl_out}, 16'h0000);
    check("R2 crc kept", crc_out, 16'h0000);

    // R3: seed load with byte width still loads 16 bits
    wr(1'b0, 1'b0, 16'h0001);
    check("R2 ctl seed", {14'h0, ctl_out}, 16'h0001);
    wr(1'b1, 1'b0, 16'hFFFF);
    check("R3 seed full width", crc_out, 16'hFFFF);

    // R8 normal check string
    wr(1'b0, 1'b0, 16'h0000);
    check("R2 crc kept after ctl", crc_out, 16'hFFFF);
    for (int i = 0; i < 9; i++) begin
      wr(1'b1, 1'b0, {8'h5A, msg[i]});
      check_crc("R4 string step");
    end
    check("R8 check 29B1", crc_out, 16'h29B1);

    // R8 transposed check string
    wr(1'b0, 1'b0, 16'h0001);
    wr(1'b1, 1'b1, 16'h0000);
    wr(1'b0, 1'b0, 16'h0002);
    check("R2 ctl xpose", {14'h0, ctl_out}, 16'h0002);
    for (int i = 0; i < 9; i++) wr(1'b1, 1'b0, {8'hC3, msg[i]});
    check("R8 check 2189", crc_out, 16'h2189);

    // R7/R3: seed taken raw, readback reversed
    wr(1'b0, 1'b0, 16'h0003);
    wr(1'b1, 1'b0, 16'h0001);
    check("R7 reversed seed readback", crc_out, 16'h8000);
    wr(1'b0, 1'b0, 16'h0001);
    check("R7 plain readback", crc_out, 16'h0001);

    // R4/R6: every byte value from several seeds, both modes; upper byte noise
    for (int x = 0; x < 2; x++) begin
      for (int s = 0; s < 4; s++) begin
        wr(1'b0, 1'b0, 16'h0001);
        wr(1'b1, 1'b0, seeds[s]);
        wr(1'b0, 1'b0, x ? 16'h0002 : 16'h0000);
        for (int b = 0; b < 256; b++) begin
          next_lfsr();
          wr(1'b1, 1'b0, {lfsr[15:8], b[7:0]});
          check_crc(x ? "R6 byte sweep transposed" : "R4 byte sweep");
        end
      end
    end

    // R5/R6: word writes in both modes
    for (int x = 0; x < 2; x++) begin
      wr(1'b0, 1'b0, 16'h0001);
      wr(1'b1, 1'b1, 16'hFFFF);
      wr(1'b0, 1'b0, x ? 16'h0002 : 16'h0000);
      for (int w = 0; w < 300; w++) begin
        next_lfsr();
        wr(1'b1, 1'b1, lfsr);
        check_crc(x ? "R6 word transposed" : "R5 word");
      end
    end

    // R9: idle cycles with toggling inputs change nothing
    begin
      logic [15:0] hold_crc;
      logic [1:0]  hold_ctl;
      hold_crc = crc_out;
      hold_ctl = ctl_out;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        wr_sel = k[0]; wr_wide = k[1]; wr_data = 16'h1111 * k[3:0];
      end
      @(negedge clk);
      check("R9 idle crc", crc_out, hold_crc);
      check("R9 idle ctl", {14'h0, ctl_out}, {14'h0, hold_ctl});
      wr(1'b1, 1'b0, 16'h0003);
      check("R9 data write keeps ctl", {14'h0, ctl_out}, {14'h0, hold_ctl});
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule